// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter for Three Masters

This block decides which of three processors owns a shared asynchronous bus. Each processor asks for the bus with an active-low request. The arbiter answers with an active-low grant. The new owner then takes the bus by driving its active-low grant-acknowledge. The arbiter also watches the shared address strobe and the data-transfer acknowledge. A grant is never offered while a bus cycle is still running, so an ownership change cannot cut into a transfer.

Fairness comes from a rotating pointer. When an owner lets go of the bus, the pointer moves to the master after it. The next grant goes to the first pending requester found when scanning from the pointer. Every input arrives from another timing domain and passes through a synchronizer before it is used. The rest of the design is synchronous to one clock, with an active-low synchronous reset.

Top module: `bus_share_arbiter`

## Requirements
- R1: During and after reset (rst_n low at a clock edge), all three grant outputs read 1 (negated) and the rotation pointer points at master 0.
- R2: Each input (req_n, ack_n, strobe_n, dtack_n) passes through a two-flop synchronizer. A request that falls just before clock edge k, with the bus idle, shows as a grant on the output after edge k+2, and not earlier.
- R3: At most one bit of grant_n is 0 at any time.
- R4: A new grant is issued only when the synchronized strobe_n is 1, the synchronized dtack_n is 1, and no ack_n bit is 0.
- R5: A grant stays asserted until the chosen master drives its ack_n to 0. After that the grant is negated.
- R6: While the owner holds its ack_n at 0, no grant is issued to any master, even if requests are pending.
- R7: When the owner releases ack_n, the pointer moves to the next master (0 to 1, 1 to 2, 2 to 0).
- R8: The winner is the first master with req_n at 0, scanning upward from the pointer and wrapping from master 2 to master 0. Bit i of each vector belongs to master i.
- R9: If a granted master returns req_n to 1 before acknowledging, its grant is negated and arbitration restarts with the pointer unchanged.
- R10: A grant goes only to a master whose synchronized request is asserted. With no requests pending, grant_n stays 3'b111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | 3 | Bus requests, active low, bit i from master i |
| ack_n | input | 3 | Grant acknowledges, active low, bit i from master i |
| strobe_n | input | 1 | Shared address strobe, active low |
| dtack_n | input | 1 | Shared data-transfer acknowledge, active low |
| grant_n | output | 3 | Bus grants, active low, bit i to master i |

## Verification
The hardest case to reach is a withdrawn grant, because the pointer must stay where it was. The bench grants master 2 alone. It then removes that request while masters 0 and 1 request in the same cycle. Master 1 must win, which only happens if the pointer did not move. The strobe and data-acknowledge gating is reached by holding each input low over a pending request for many cycles before releasing it.

// File: rtl/arb_pkg.sv
// Package: shared types and helpers for the rotating-priority arbiter.
// Assumes master indices run 0..n-1 and fit a small unsigned field.
package arb_pkg;

    // Arbiter control states: idle, grant offered, bus held by owner.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_HELD  = 2'd2
    } arb_state_t;

    // Index of the master after idx, wrapping at n.
    function automatic int unsigned next_master(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/arb_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency needed) and
// resets to RST_VAL with a synchronous active-low reset.
module arb_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
                    else        stage_q[s] <= d_async;
                end
            end else begin : g_next
                // Later flops pass the value down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/arb_rr_pick.sv
// Module: round-robin winner selection (pure combinational).
// Assumes ptr < N. Returns the first set bit of req scanning upward
// from ptr with wrap-around, plus a flag when any bit is set.
module arb_rr_pick #(
    parameter int N = 3,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] ptr,
    output logic [W-1:0] win,
    output logic         any
);

    logic [2*N-1:0] dbl;
    logic [N-1:0]   rot;
    logic [W-1:0]   enc;
    logic [W:0]     sum;

    // Rotate the request vector so the pointer position lands at bit 0.
    always_comb begin
        dbl = {req, req} >> ptr;
        rot = dbl[N-1:0];
    end

    // Priority-encode the rotated vector, lowest bit first.
    always_comb begin
        enc = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (rot[k]) enc = W'(k);
        end
    end

    // Undo the rotation to get the absolute master index.
    always_comb begin
        sum = {1'b0, ptr} + {1'b0, enc};
        if (sum >= (W+1)'(N)) sum = sum - (W+1)'(N);
        win = sum[W-1:0];
    end

    assign any = |req;

endmodule

// File: rtl/arb_ctrl.sv
// Module: ownership state machine and rotation pointer.
// Assumes all inputs are already synchronized and active high
// (req, ack asserted = 1; bus_quiet = strobe and data-ack negated).
// Grants are registered and one-hot or zero.
module arb_ctrl
    import arb_pkg::*;
#(
    parameter int N = 3,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] ack,
    input  logic         bus_quiet,
    input  logic [W-1:0] win,
    input  logic         any_req,
    output logic [W-1:0] ptr,
    output logic [N-1:0] grant
);

    arb_state_t   state_q;
    logic [W-1:0] owner_q;
    logic [W-1:0] ptr_q;
    logic [N-1:0] grant_q;
    logic         may_offer;

    // Conditions under which a fresh grant may be issued.
    assign may_offer = any_req && bus_quiet && !(|ack);

    // Drive the state, owner, pointer and grant registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            ptr_q   <= '0;
            grant_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (may_offer) begin
                        grant_q <= N'(1) << win;
                        owner_q <= win;
                        state_q <= ST_OFFER;
                    end
                end
                ST_OFFER: begin
                    if (ack[owner_q]) begin
                        grant_q <= '0;
                        state_q <= ST_HELD;
                    end else if (!req[owner_q]) begin
                        grant_q <= '0;
                        state_q <= ST_IDLE;
                    end
                end
                ST_HELD: begin
                    if (!ack[owner_q]) begin
                        ptr_q   <= W'(next_master(int'(owner_q), N));
                        state_q <= ST_IDLE;
                    end
                end
                default: begin
                    grant_q <= '0;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign ptr   = ptr_q;
    assign grant = grant_q;

endmodule

// File: rtl/bus_share_arbiter.sv
// Module: top of the three-master rotating-priority bus arbiter.
// Assumes all bus-side inputs are asynchronous and active low; the
// grants it drives are registered and active low.
module bus_share_arbiter #(
    parameter int NUM_MASTERS = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req_n,
    input  logic [NUM_MASTERS-1:0] ack_n,
    input  logic                   strobe_n,
    input  logic                   dtack_n,
    output logic [NUM_MASTERS-1:0] grant_n
);

    localparam int W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

    logic [NUM_MASTERS-1:0] s_req_n;
    logic [NUM_MASTERS-1:0] s_ack_n;
    logic                   s_strobe_n;
    logic                   s_dtack_n;
    logic [W-1:0]           ptr;
    logic [W-1:0]           win;
    logic                   any_req;
    logic [NUM_MASTERS-1:0] grant;

    arb_sync #(.WIDTH(NUM_MASTERS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_req (
        .clk(clk), .rst_n(rst_n), .d_async(req_n), .q_sync(s_req_n));

    arb_sync #(.WIDTH(NUM_MASTERS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ack (
        .clk(clk), .rst_n(rst_n), .d_async(ack_n), .q_sync(s_ack_n));

    arb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_as (
        .clk(clk), .rst_n(rst_n), .d_async(strobe_n), .q_sync(s_strobe_n));

    arb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dt (
        .clk(clk), .rst_n(rst_n), .d_async(dtack_n), .q_sync(s_dtack_n));

    arb_rr_pick #(.N(NUM_MASTERS)) u_pick (
        .req(~s_req_n), .ptr(ptr), .win(win), .any(any_req));

    arb_ctrl #(.N(NUM_MASTERS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req(~s_req_n), .ack(~s_ack_n),
        .bus_quiet(s_strobe_n & s_dtack_n),
        .win(win), .any_req(any_req),
        .ptr(ptr), .grant(grant));

    assign grant_n = ~grant;

endmodule

// File: rtl/arb_checker.sv
// Module: property checker for the bus arbiter, bound to its top.
// Assumes synchronized signals are visible by name in the top.
module arb_checker #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] grant_n,
    input logic [N-1:0] s_req_n,
    input logic [N-1:0] s_ack_n,
    input logic         s_strobe_n,
    input logic         s_dtack_n
);

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~grant_n) <= 1); // R3

    AST_GRANT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(grant_n) & ~grant_n) != '0) |->
            $past(s_strobe_n && s_dtack_n && (&s_ack_n))); // R4

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_per
            AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(!grant_n[i]) && $past(s_ack_n[i]) && $past(!s_req_n[i]))
                    |-> !grant_n[i]); // R5

            AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(grant_n[i]) && !grant_n[i]) |-> $past(!s_req_n[i])); // R10
        end
    endgenerate

endmodule

bind bus_share_arbiter arb_checker #(.N(NUM_MASTERS)) u_chk (
    .clk(clk), .rst_n(rst_n), .grant_n(grant_n),
    .s_req_n(s_req_n), .s_ack_n(s_ack_n),
    .s_strobe_n(s_strobe_n), .s_dtack_n(s_dtack_n));

// File: tb/sim_bus_share_arbiter.sv
`timescale 1ns/1ps
module sim_bus_share_arbiter;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] req_n;
    logic [2:0] ack_n;
    logic       strobe_n;
    logic       dtack_n;
    logic [2:0] grant_n;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    bus_share_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .ack_n(ack_n),
        .strobe_n(strobe_n), .dtack_n(dtack_n), .grant_n(grant_n));

    always #10 clk = ~clk;

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [2:0] exp);
        total++;
        if (grant_n !== exp) begin
            bad++;
            $display("FAIL %s grant_n actual=%b expected=%b", tag, grant_n, exp);
        end
    endtask

    // Owner m acknowledges, then releases ack and request.
    task automatic own(input int m);
        ack_n[m] = 1'b0;
        wait_cyc(5);
        chk("R5 grant negated after ack", 3'b111);
        ack_n[m] = 1'b1;
        req_n[m] = 1'b1;
        wait_cyc(6);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; req_n = 3'b111; ack_n = 3'b111;
        strobe_n = 1'b1; dtack_n = 1'b1;
        wait_cyc(5);
        chk("R1 reset grants negated", 3'b111);
        rst_n = 1'b1;
        wait_cyc(8);
        chk("R10 no request no grant", 3'b111);
    endtask

    // Pointer 0, only master 1 requests; exact latency.
    task automatic t_latency;
        req_n[1] = 1'b0;
        wait_cyc(2);
        chk("R2 no grant before third edge", 3'b111);
        wait_cyc(1);
        chk("R2 R8 grant to master 1 on third edge", 3'b101);
        own(1); // pointer now 2
    endtask

    // All request: order 2, 0, 1 from pointer 2.
    task automatic t_rotate;
        req_n = 3'b000;
        wait_cyc(6);
        chk("R8 R3 single grant to master 2", 3'b011);
        own(2);
        chk("R7 wrap to master 0", 3'b110);
        own(0);
        chk("R7 master 1 follows 0", 3'b101);
        own(1); // pointer 2
    endtask

    task automatic t_strobe;
        strobe_n = 1'b0;
        req_n[0] = 1'b0;
        wait_cyc(12);
        chk("R4 no grant during strobe", 3'b111);
        strobe_n = 1'b1;
        wait_cyc(6);
        chk("R4 grant after strobe ends", 3'b110);
        own(0); // pointer 1
    endtask

    task automatic t_dtack;
        dtack_n = 1'b0;
        req_n[2] = 1'b0;
        wait_cyc(12);
        chk("R4 no grant during data ack", 3'b111);
        dtack_n = 1'b1;
        wait_cyc(6);
        chk("R4 grant after data ack ends", 3'b011);
        own(2); // pointer 0
    endtask

    task automatic t_hold;
        req_n[1] = 1'b0;
        wait_cyc(6);
        chk("R8 master 1 from pointer 0", 3'b101);
        ack_n[1] = 1'b0;
        wait_cyc(5);
        req_n[0] = 1'b0;
        req_n[2] = 1'b0;
        wait_cyc(12);
        chk("R6 no grant while owner holds", 3'b111);
        ack_n[1] = 1'b1;
        req_n[1] = 1'b1;
        wait_cyc(6);
        chk("R7 pointer moved past owner 1", 3'b011);
        own(2);
        chk("R7 master 0 after 2", 3'b110);
        own(0); // pointer 1
    endtask

    task automatic t_withdraw;
        req_n[2] = 1'b0;
        wait_cyc(6);
        chk("R8 master 2 from pointer 1", 3'b011);
        req_n[2] = 1'b1;
        req_n[0] = 1'b0;
        req_n[1] = 1'b0;
        wait_cyc(3);
        chk("R9 grant to 2 dropped", 3'b111);
        wait_cyc(4);
        chk("R9 pointer unchanged, master 1 wins", 3'b101);
        own(1);
        chk("R7 after withdraw cycle", 3'b110);
        own(0);
        wait_cyc(6);
        chk("R10 idle after all released", 3'b111);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_rotate();
        t_strobe();
        t_dtack();
        t_hold();
        t_withdraw();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule